// File: doc/BRIEF.md
# Floating-Point Control/Status Word and Exception Gate

This block holds the two 16-bit words that steer and report a floating-point unit: the control word, which holds the six exception masks, the precision field and the rounding field, and the status word. The status word holds six sticky exception flags, a stack-fault flag, an error-summary bit, a busy bit, four condition codes and the 3-bit stack-top pointer. The arithmetic and stack units report events through plain sticky-set pins. They read the rounding mode and the control word back through plain output pins.

Commands arrive on a valid/ready stream: no-op, init, clear-exceptions, load control word, store control word and store status word. A store returns its word on a valid/ready read stream. The command stream stalls (`cmd_ready` low) only while a stored word is waiting and `rd_ready` is low. During that stall, `rd_valid` and `rd_data` hold. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high.

The block also runs the wait check. Each exception flag is paired with its own mask bit, and the stack-fault flag is paired with the invalid-operation mask. The result is a registered level output, `fault_req`, that stays high for as long as such a pending condition exists.

Top module: `fpu_ctl_status`

## Requirements
- R1: After reset the control word is 0x037F, the status word is 0x0000, `fault_req` and `rd_valid` are 0, `cmd_ready` is 1 and `round_mode` is 0.
- R2: Each `exc_set[i]` pulse sets status bit i (0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision), and `sf_set` sets bit 6. The change is visible on `sw_out` after the sampling edge, and the bit stays set until clear-exceptions or init.
- R3: `fault_req` is 1 one cycle after the status and control words show some exception flag i (bits 0..5) set while control bit i is 0. It is 0 one cycle after no such pair exists.
- R4: The stack-fault flag (status bit 6) raises `fault_req` only while control bit 0 is 0. With all six masks set, `fault_req` is 0.
- R5: Clear-exceptions (`cmd_op` 2) clears status bits 0..5, 7 (error summary) and 15 (busy). It keeps the stack-fault flag, the condition codes (bits 8, 9, 10, 14) and the top pointer (bits 13:11).
- R6: When clear-exceptions is accepted in the same cycle as an `exc_set` pulse, bits 0..5 end up 0.
- R7: Init (`cmd_op` 1) loads the control word with 0x037F and clears the whole status word. It wins over flag, condition-code and top writes in the same cycle.
- R8: Load control word (`cmd_op` 3) copies `cmd_data` into the control word. `round_mode` shows control bits 11:10, where 0 is nearest, 1 is down, 2 is up and 3 is toward zero.
- R9: Store control word (`cmd_op` 4) and store status word (`cmd_op` 5) raise `rd_valid` one cycle after acceptance. `rd_data` then carries the word as it was before the accepting edge.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `cmd_ready` is 0, `rd_data` holds, and a command offered in that time has no effect.
- R11: `cc_we` writes `cc_in` bits 0, 1, 2 and 3 into status bits 8, 9, 10 and 14, and `top_we` writes `top_in` into bits 13:11.
- R12: The error-summary bit 7 and the busy bit 15 are set one cycle after an exception flag meets a clear mask bit, and they stay set until clear-exceptions or init.
- R13: `cmd_op` 0, 6 and 7 change neither word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 16 | Word for load control word |
| rd_valid | output | 1 | Stored word available |
| rd_ready | input | 1 | Consumer takes the stored word |
| rd_data | output | 16 | Stored word |
| exc_set | input | 6 | Sticky exception flag sets |
| sf_set | input | 1 | Sticky stack-fault set |
| cc_we | input | 1 | Condition-code write enable |
| cc_in | input | 4 | Condition codes {C3,C2,C1,C0} |
| top_we | input | 1 | Top pointer write enable |
| top_in | input | 3 | New top pointer |
| cw_out | output | 16 | Current control word |
| sw_out | output | 16 | Current status word |
| round_mode | output | 2 | Rounding mode for arithmetic units |
| fault_req | output | 1 | Wait check fault request (level) |

## Verification
A flag that fails to stick, or a clear that reaches the condition codes or the top pointer, shows on `sw_out` right after the edge concerned. A wrong pairing between a mask and a flag shows on `fault_req` exactly one cycle after the words change. The tests cover every mask position on its own, so a miswired pair cannot hide behind another flag. A lost snapshot or an early release of the read register shows on `rd_data` while back-pressure is applied, and on `cw_out` if a stalled command leaks through.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int WORD_W  = 16;
  localparam int NUM_EXC = 6;
  localparam int TOP_W   = 3;
  localparam int CC_W    = 4;
  localparam int RC_W    = 2;

  localparam int SW_SF   = 6;
  localparam int SW_ES   = 7;
  localparam int SW_C0   = 8;
  localparam int SW_C1   = 9;
  localparam int SW_C2   = 10;
  localparam int SW_TOPL = 11;
  localparam int SW_C3   = 14;
  localparam int SW_BUSY = 15;
  localparam int CW_RCL  = 10;
  localparam int CW_IM   = 0;

  localparam logic [WORD_W-1:0] CW_DEFAULT = 16'h037F;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_INIT = 3'd1,
    OP_CLEX = 3'd2,
    OP_LDCW = 3'd3,
    OP_STCW = 3'd4,
    OP_STSW = 3'd5
  } fpsc_op_e;

  typedef struct packed {
    logic init;
    logic clex;
    logic ldcw;
  } fpsc_ctl_s;
endpackage

// File: rtl/fpsc_cmd_port.sv
module fpsc_cmd_port
  import fpsc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [W-1:0]  rd_data,
  input  logic [W-1:0]  cw_q,
  input  logic [W-1:0]  sw_q,
  output fpsc_ctl_s     ctl,
  output logic [W-1:0]  ld_data
);
  logic         accept;
  logic         want_cw, want_sw;
  logic         rd_valid_q;
  logic [W-1:0] rd_data_q;

  assign cmd_ready = !rd_valid_q || rd_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign ld_data   = cmd_data;

  always_comb begin
    ctl     = '0;
    want_cw = 1'b0;
    want_sw = 1'b0;
    if (accept) begin
      case (cmd_op)
        OP_INIT: ctl.init = 1'b1;
        OP_CLEX: ctl.clex = 1'b1;
        OP_LDCW: ctl.ldcw = 1'b1;
        OP_STCW: want_cw  = 1'b1;
        OP_STSW: want_sw  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else if (want_cw || want_sw) begin
      rd_valid_q <= 1'b1;
      rd_data_q  <= want_cw ? cw_q : sw_q;
    end else if (rd_ready) begin
      rd_valid_q <= 1'b0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10
endmodule

// File: rtl/fpsc_ctrl_word.sv
module fpsc_ctrl_word
  import fpsc_pkg::*;
#(
  parameter int               W        = WORD_W,
  parameter logic [W-1:0]     CW_RESET = CW_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fpsc_ctl_s         ctl,
  input  logic [W-1:0]      ld_data,
  output logic [W-1:0]      cw_q,
  output logic [NUM_EXC-1:0] mask,
  output logic [RC_W-1:0]   round_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cw_q <= CW_RESET;
    else if (ctl.init) cw_q <= CW_RESET;
    else if (ctl.ldcw) cw_q <= ld_data;
  end

  assign mask       = cw_q[NUM_EXC-1:0];
  assign round_mode = cw_q[CW_RCL +: RC_W];

  AST_INIT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.init |=> (cw_q == CW_RESET)); // R7
endmodule

// File: rtl/fpsc_stat_word.sv
module fpsc_stat_word
  import fpsc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fpsc_ctl_s          ctl,
  input  logic [NUM_EXC-1:0] exc_set,
  input  logic               sf_set,
  input  logic               cc_we,
  input  logic [CC_W-1:0]    cc_in,
  input  logic               top_we,
  input  logic [TOP_W-1:0]   top_in,
  input  logic [NUM_EXC-1:0] mask,
  output logic [W-1:0]       sw_q
);
  logic [NUM_EXC-1:0] flg_q, flg_d;
  logic               sf_q, sf_d, es_q, es_d;
  logic [CC_W-1:0]    cc_q, cc_d;
  logic [TOP_W-1:0]   top_q, top_d;
  logic               pend_d;

  always_comb begin
    flg_d  = ctl.clex ? '0 : (flg_q | exc_set);
    sf_d   = sf_q | sf_set;
    cc_d   = cc_we  ? cc_in  : cc_q;
    top_d  = top_we ? top_in : top_q;
    pend_d = (|(flg_d & ~mask)) || (sf_d && !mask[CW_IM]);
    es_d   = !ctl.clex && (es_q || pend_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || 1'b0) begin
      flg_q <= '0;
      sf_q  <= 1'b0;
      es_q  <= 1'b0;
      cc_q  <= '0;
      top_q <= '0;
    end else if (ctl.init) begin
      flg_q <= '0;
      sf_q  <= 1'b0;
      es_q  <= 1'b0;
      cc_q  <= '0;
      top_q <= '0;
    end else begin
      flg_q <= flg_d;
      sf_q  <= sf_d;
      es_q  <= es_d;
      cc_q  <= cc_d;
      top_q <= top_d;
    end
  end

  always_comb begin
    sw_q                   = '0;
    sw_q[NUM_EXC-1:0]      = flg_q;
    sw_q[SW_SF]            = sf_q;
    sw_q[SW_ES]            = es_q;
    sw_q[SW_C0]            = cc_q[0];
    sw_q[SW_C1]            = cc_q[1];
    sw_q[SW_C2]            = cc_q[2];
    sw_q[SW_TOPL +: TOP_W] = top_q;
    sw_q[SW_C3]            = cc_q[3];
    sw_q[SW_BUSY]          = es_q;
  end

  AST_CLEX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clex |=> (sw_q[NUM_EXC-1:0] == '0)); // R6
  AST_FLAGS_STICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.clex && !ctl.init) |=>
      ((sw_q[SW_SF:0] & $past(sw_q[SW_SF:0])) == $past(sw_q[SW_SF:0]))); // R2
  AST_CLEX_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clex && !cc_we && !top_we) |=> $stable(sw_q[SW_C3:SW_C0])); // R5
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.init |=> (sw_q == '0)); // R7
endmodule

// File: rtl/fpsc_wait_gate.sv
module fpsc_wait_gate
  import fpsc_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       sw_q,
  input  logic [NUM_EXC-1:0] mask,
  output logic               fault_req
);
  logic [NUM_EXC:0] pend;
  logic             fault_q;

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_pair
    assign pend[i] = sw_q[i] && !mask[i];
  end
  assign pend[NUM_EXC] = sw_q[SW_SF] && !mask[CW_IM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= |pend;
  end

  assign fault_req = fault_q;

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |=> !fault_req); // R4
  AST_SF_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_q[SW_SF] && !mask[CW_IM]) |=> fault_req); // R4
endmodule

// File: rtl/fpu_ctl_status.sv
module fpu_ctl_status
  import fpsc_pkg::*;
#(
  parameter logic [15:0] CW_RESET = CW_DEFAULT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic [15:0] cmd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [15:0] rd_data,
  input  logic [5:0]  exc_set,
  input  logic        sf_set,
  input  logic        cc_we,
  input  logic [3:0]  cc_in,
  input  logic        top_we,
  input  logic [2:0]  top_in,
  output logic [15:0] cw_out,
  output logic [15:0] sw_out,
  output logic [1:0]  round_mode,
  output logic        fault_req
);
  fpsc_ctl_s          ctl;
  logic [15:0]        ld_data, cw_q, sw_q;
  logic [NUM_EXC-1:0] mask;

  fpsc_cmd_port #(.W(16)) u_port (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .cw_q(cw_q), .sw_q(sw_q),
    .ctl(ctl), .ld_data(ld_data));

  fpsc_ctrl_word #(.W(16), .CW_RESET(CW_RESET)) u_cw (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .ld_data(ld_data), .cw_q(cw_q),
    .mask(mask), .round_mode(round_mode));

  fpsc_stat_word #(.W(16)) u_sw (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .exc_set(exc_set), .sf_set(sf_set),
    .cc_we(cc_we), .cc_in(cc_in), .top_we(top_we), .top_in(top_in),
    .mask(mask), .sw_q(sw_q));

  fpsc_wait_gate #(.W(16)) u_gate (
    .clk(clk), .rst_n(rst_n), .sw_q(sw_q), .mask(mask), .fault_req(fault_req));

  assign cw_out = cw_q;
  assign sw_out = sw_q;
endmodule

// File: tb/tb_fpu_ctl_status.sv
module tb_fpu_ctl_status;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CWD = 16'h037F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_data = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [15:0] rd_data;
  logic [5:0]  exc_set = '0;
  logic        sf_set = 1'b0, cc_we = 1'b0, top_we = 1'b0;
  logic [3:0]  cc_in = '0;
  logic [2:0]  top_in = '0;
  logic [15:0] cw_out, sw_out;
  logic [1:0]  round_mode;
  logic        fault_req;
  int errors = 0, checks = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_ctl_status dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .exc_set(exc_set),
    .sf_set(sf_set), .cc_we(cc_we), .cc_in(cc_in), .top_we(top_we),
    .top_in(top_in), .cw_out(cw_out), .sw_out(sw_out),
    .round_mode(round_mode), .fault_req(fault_req));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    tick();
    cmd_valid = 1'b0; cmd_op = '0;
  endtask

  task automatic pulse_exc(input logic [5:0] f);
    exc_set = f; tick(); exc_set = '0;
  endtask

  task automatic take_rd(input string req, input logic [15:0] exp);
    chk({req, " rd_valid"}, {15'd0, rd_valid}, 16'd1);
    chk({req, " rd_data"}, rd_data, exp);
    rd_ready = 1'b1; tick(); rd_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cw", cw_out, CWD);
    chk("R1 sw", sw_out, 16'h0000);
    chk("R1 fault", {15'd0, fault_req}, 16'd0);
    chk("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
    chk("R1 cmd_ready", {15'd0, cmd_ready}, 16'd1);
    chk("R1 round", {14'd0, round_mode}, 16'd0);
  endtask

  task automatic t_sticky_and_unmask();
    pulse_exc(6'b000100);
    chk("R2 ze set", sw_out, 16'h0004);
    tick();
    chk("R2 ze sticky", sw_out, 16'h0004);
    chk("R3 masked no fault", {15'd0, fault_req}, 16'd0);
    issue(3'd3, 16'h037B);
    chk("R8 ldcw", cw_out, 16'h037B);
    tick();
    chk("R3 fault on unmask", {15'd0, fault_req}, 16'd1);
    chk("R12 es and busy", sw_out, 16'h8084);
  endtask

  task automatic t_cc_and_clex();
    cc_we = 1'b1; cc_in = 4'b1011; top_we = 1'b1; top_in = 3'd5;
    tick();
    cc_we = 1'b0; top_we = 1'b0;
    chk("R11 cc and top", sw_out, 16'hEB84);
    issue(3'd2, 16'h0);
    chk("R5 clex keeps cc/top", sw_out, 16'h6B00);
    tick();
    chk("R3 fault drops", {15'd0, fault_req}, 16'd0);
  endtask

  task automatic t_clex_priority();
    exc_set = 6'b000100;
    issue(3'd2, 16'h0);
    exc_set = '0;
    chk("R6 clex beats set", sw_out, 16'h6B00);
    tick();
    chk("R6 no fault", {15'd0, fault_req}, 16'd0);
  endtask

  task automatic t_stack_fault();
    sf_set = 1'b1; tick(); sf_set = 1'b0;
    chk("R2 sf set", sw_out, 16'h6B40);
    tick();
    chk("R4 sf masked by IM", {15'd0, fault_req}, 16'd0);
    issue(3'd3, 16'h037E);
    tick();
    chk("R4 sf unmasked", {15'd0, fault_req}, 16'd1);
    chk("R12 es from sf", sw_out, 16'hEBC0);
    issue(3'd2, 16'h0);
    chk("R5 clex keeps sf", sw_out, 16'h6B40);
    tick();
    chk("R4 fault persists", {15'd0, fault_req}, 16'd1);
  endtask

  task automatic t_init_priority();
    exc_set = 6'b111111; sf_set = 1'b1; cc_we = 1'b1; cc_in = 4'hF;
    top_we = 1'b1; top_in = 3'd7;
    issue(3'd1, 16'h0);
    exc_set = '0; sf_set = 1'b0; cc_we = 1'b0; top_we = 1'b0;
    chk("R7 init sw", sw_out, 16'h0000);
    chk("R7 init cw", cw_out, CWD);
    tick();
    chk("R7 fault clear", {15'd0, fault_req}, 16'd0);
  endtask

  task automatic t_round();
    issue(3'd3, 16'h077F); chk("R8 round down", {14'd0, round_mode}, 16'd1);
    issue(3'd3, 16'h0B7F); chk("R8 round up", {14'd0, round_mode}, 16'd2);
    issue(3'd3, 16'h0F7F); chk("R8 trunc", {14'd0, round_mode}, 16'd3);
    issue(3'd3, 16'h037F); chk("R8 nearest", {14'd0, round_mode}, 16'd0);
  endtask

  task automatic t_store();
    pulse_exc(6'b100000);
    exc_set = 6'b000001;
    issue(3'd5, 16'h0);
    exc_set = '0;
    chk("R9 rd_data pre-edge", rd_data, 16'h0020);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_data = 16'h0000;
    for (int k = 0; k < 3; k++) begin
      chk("R10 stalled", {15'd0, cmd_ready}, 16'd0);
      chk("R10 rd hold", rd_data, 16'h0020);
      tick();
    end
    cmd_valid = 1'b0;
    take_rd("R9 stsw", 16'h0020);
    chk("R10 rd released", {15'd0, rd_valid}, 16'd0);
    chk("R10 stalled cmd ignored", cw_out, CWD);
    issue(3'd4, 16'h0);
    take_rd("R9 stcw", CWD);
  endtask

  task automatic t_ignored_ops();
    logic [15:0] sw0;
    sw0 = sw_out;
    issue(3'd0, 16'hFFFF);
    issue(3'd6, 16'h0000);
    issue(3'd7, 16'h1234);
    chk("R13 cw unchanged", cw_out, CWD);
    chk("R13 sw unchanged", sw_out, sw0);
    chk("R13 no read", {15'd0, rd_valid}, 16'd0);
  endtask

  task automatic t_mask_pairs();
    for (int i = 0; i < 6; i++) begin
      int j;
      j = (i + 1) % 6;
      issue(3'd1, 16'h0);
      issue(3'd3, CWD & ~(16'd1 << i));
      pulse_exc(6'd1 << j);
      tick();
      chk($sformatf("R3 other flag %0d masked", j), {15'd0, fault_req}, 16'd0);
      pulse_exc(6'd1 << i);
      tick();
      chk($sformatf("R3 flag %0d unmasked", i), {15'd0, fault_req}, 16'd1);
    end
    issue(3'd1, 16'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        errors++;
        $display("FAIL watchdog R1-all: actual=%0d cycles expected<50000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sticky_and_unmask();
    t_cc_and_clex();
    t_clex_priority();
    t_stack_fault();
    t_init_priority();
    t_round();
    t_store();
    t_ignored_ops();
    t_mask_pairs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule